// File: doc/BRIEF.md
# Descriptor Fetch FIFO Error Controller

This block holds the queue of descriptor pointers waiting to be fetched by one processing channel, together with a sticky error status vector and the channel's run/halt state. The host posts pointers through a write port. The channel side takes them in arrival order through a valid/ready pair, and it can only do so while the channel is running.

Faults come from several places. A host write may overflow the queue. The channel may fetch a pointer that is all zeros. The bus-master side may raise a transfer error strobe, and an engine may hold a level error line high. Each fault sets its own status bit, and the interrupt line stays high while any bit is set. Severe faults halt the channel. The host clears bits by writing ones to them. A continue pulse or a reset pulse restarts a halted channel.

A small progress field counts the pointer dword positions of the current descriptor. It reports a fixed error code while the channel is halted.

Top module: `desc_fetch_err_ctrl`

## Requirements
- R1: A push with `push_valid_i` high while the queue holds fewer than DEPTH (default 4) entries is stored. Stored pointers leave on `pop_ptr_o` in arrival order, one per cycle in which `pop_valid_o` and `pop_ready_i` are both high.
- R2: A push while the queue is full and status bit 1 (single overflow) is clear does the following: it discards the pointer, sets bit 1 on the next cycle, and leaves `halted_o` low.
- R3: A push while the queue is full and bit 1 is already set sets bit 0 (double overflow) and halts the channel on the next cycle. Bit 1 stays set.
- R4: While halted, `pop_valid_o` is low. The halt persists until a `cont_i` or `rst_cmd_i` pulse. A continue pulse clears the halt but keeps the queued pointers and all status bits.
- R5: A `bus_err_i` pulse sets bit 2 (master transfer error) and halts the channel on the next cycle.
- R6: Fetching a pointer of value zero delivers it unchanged and sets bit 3 (zero pointer) on the next cycle.
- R7: Bit 4 (engine error) is set while `eu_err_i` is high. A host clear of bit 4 has no effect while the source is high. After the source drops, the bit stays set until it is cleared.
- R8: A cycle with `clr_we_i` high clears exactly the status bits whose `clr_mask_i` bit is 1. Zero mask bits leave their status bits unchanged. A fault arriving in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when at least one status bit is set.
- R10: `pair_ptr_o` starts at 0. Each `dword_adv_i` pulse while running steps it 0, 1, 2 and then back to 0. It reads 3 while halted.
- R11: A `rst_cmd_i` pulse empties the queue, clears all status bits other than a bit 4 whose source is still high, clears the halt and returns `pair_ptr_o` to 0.
- R12: After `rst_ni` is released, the queue is empty, all status bits are 0, `irq_o` and `halted_o` are low, and `pair_ptr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_valid_i | input | 1 | Host pointer write strobe |
| push_ptr_i | input | PTR_W | Pointer being written |
| pop_ready_i | input | 1 | Channel takes the head pointer |
| pop_valid_o | output | 1 | Head pointer available and channel running |
| pop_ptr_o | output | PTR_W | Head pointer |
| bus_err_i | input | 1 | Bus-master transfer error strobe |
| eu_err_i | input | 1 | Engine error source level |
| clr_we_i | input | 1 | Status clear write strobe |
| clr_mask_i | input | 5 | Write-one-to-clear mask |
| cont_i | input | 1 | Continue command pulse |
| rst_cmd_i | input | 1 | Channel reset command pulse |
| dword_adv_i | input | 1 | Advance pointer dword position |
| err_o | output | 5 | Status bits: 0 double overflow, 1 single overflow, 2 master error, 3 zero pointer, 4 engine error |
| irq_o | output | 1 | Error interrupt |
| halted_o | output | 1 | Channel halted |
| pair_ptr_o | output | 2 | Progress: 0, 1, 2, or 3 while halted |

## Verification
The bench fills the queue and writes into it once and then twice more. A design that kept the extra pointer would show up as a surplus item in the scoreboard, and one that halted on the first overflow would leave `pop_valid_o` low. While halted it holds `pop_ready_i` high and then issues a continue. A design that flushed on continue or cleared status would lose the four expected pointers or the overflow bits. It tries to clear the engine bit while its source is still high, and it clears one bit out of two that are set. A reset command with queued pointers must leave nothing to pop.

// File: rtl/dfe_pkg.sv
`timescale 1ns/1ps
package dfe_pkg;
  localparam int ERR_W    = 5;
  localparam int E_DOF    = 0;
  localparam int E_SOF    = 1;
  localparam int E_MDTE   = 2;
  localparam int E_FPZ    = 3;
  localparam int E_EU     = 4;
  localparam logic [1:0] PAIR_LAST = 2'd2;
  localparam logic [1:0] PAIR_HALT = 2'd3;
  typedef logic [ERR_W-1:0] err_vec_t;
endpackage

// File: rtl/dfe_fifo.sv
`timescale 1ns/1ps
module dfe_fifo #(
  parameter int PTR_W = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [PTR_W-1:0] din_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] dout_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [PTR_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == FULL);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/dfe_status.sv
`timescale 1ns/1ps
module dfe_status
  import dfe_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wipe_i,
  input  err_vec_t set_i,
  input  logic     clr_we_i,
  input  err_vec_t clr_mask_i,
  input  logic     eu_src_i,
  output err_vec_t err_o
);
  err_vec_t err_q, clr, nxt;

  assign clr = clr_we_i ? clr_mask_i : '0;

  always_comb begin
    nxt       = (err_q & ~clr) | set_i;
    // engine bit is held by its source; a clear only lands once it is gone
    nxt[E_EU] = eu_src_i | (err_q[E_EU] & ~clr[E_EU]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= '0;
    else if (wipe_i) begin
      err_q       <= '0;
      err_q[E_EU] <= eu_src_i;
    end else         err_q <= nxt;
  end

  assign err_o = err_q;
endmodule

// File: rtl/dfe_ctrl.sv
`timescale 1ns/1ps
module dfe_ctrl
  import dfe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_set_i,
  input  logic       cont_i,
  input  logic       rst_cmd_i,
  input  logic       adv_i,
  output logic       halted_o,
  output logic [1:0] pair_o
);
  logic       halt_q;
  logic [1:0] pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      pair_q <= '0;
    end else if (rst_cmd_i) begin
      halt_q <= 1'b0;
      pair_q <= '0;
    end else begin
      if (halt_set_i)  halt_q <= 1'b1;
      else if (cont_i) halt_q <= 1'b0;
      if (adv_i && !halt_q)
        pair_q <= (pair_q == PAIR_LAST) ? '0 : pair_q + 1'b1;
    end
  end

  assign halted_o = halt_q;
  assign pair_o   = halt_q ? PAIR_HALT : pair_q;
endmodule

// File: rtl/desc_fetch_err_ctrl.sv
`timescale 1ns/1ps
module desc_fetch_err_ctrl
  import dfe_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_valid_i,
  input  logic [PTR_W-1:0] push_ptr_i,
  input  logic             pop_ready_i,
  output logic             pop_valid_o,
  output logic [PTR_W-1:0] pop_ptr_o,
  input  logic             bus_err_i,
  input  logic             eu_err_i,
  input  logic             clr_we_i,
  input  logic [ERR_W-1:0] clr_mask_i,
  input  logic             cont_i,
  input  logic             rst_cmd_i,
  input  logic             dword_adv_i,
  output logic [ERR_W-1:0] err_o,
  output logic             irq_o,
  output logic             halted_o,
  output logic [1:0]       pair_ptr_o
);
  logic     fifo_full, fifo_empty, pop_fire, ovf;
  err_vec_t err, err_set;

  assign pop_valid_o = !fifo_empty && !halted_o;
  assign pop_fire    = pop_valid_o && pop_ready_i && !rst_cmd_i;
  assign ovf         = push_valid_i && fifo_full;

  always_comb begin
    err_set         = '0;
    err_set[E_SOF]  = ovf;
    err_set[E_DOF]  = ovf && err[E_SOF];
    err_set[E_MDTE] = bus_err_i;
    err_set[E_FPZ]  = pop_fire && (pop_ptr_o == '0);
  end

  dfe_fifo #(.PTR_W(PTR_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rst_cmd_i),
    .push_i  (push_valid_i),
    .din_i   (push_ptr_i),
    .pop_i   (pop_fire),
    .dout_o  (pop_ptr_o),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  dfe_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wipe_i     (rst_cmd_i),
    .set_i      (err_set),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .eu_src_i   (eu_err_i),
    .err_o      (err)
  );

  dfe_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_set_i (err_set[E_DOF] | err_set[E_MDTE]),
    .cont_i     (cont_i),
    .rst_cmd_i  (rst_cmd_i),
    .adv_i      (dword_adv_i),
    .halted_o   (halted_o),
    .pair_o     (pair_ptr_o)
  );

  assign err_o = err;
  assign irq_o = |err;
endmodule

// File: rtl/dfe_chk.sv
`timescale 1ns/1ps
module dfe_chk
  import dfe_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_valid_i,
  input logic             bus_err_i,
  input logic             eu_err_i,
  input logic             cont_i,
  input logic             rst_cmd_i,
  input logic             full_i,
  input logic             halted_o,
  input logic             pop_valid_o,
  input logic [1:0]       pair_ptr_o,
  input logic [ERR_W-1:0] err_o
);
  assert_sof_on_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_i && full_i && !rst_cmd_i |=> err_o[E_SOF]);

  assert_dof_halts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_i && full_i && err_o[E_SOF] && !rst_cmd_i |=> err_o[E_DOF] && halted_o);

  assert_halt_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !cont_i && !rst_cmd_i |=> halted_o);

  assert_no_pop_halted_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> !pop_valid_o);

  assert_mdte_halts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_i && !rst_cmd_i |=> err_o[E_MDTE] && halted_o);

  assert_eu_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eu_err_i |=> err_o[E_EU]);

  assert_pair_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_o |-> pair_ptr_o != PAIR_HALT);
endmodule

bind desc_fetch_err_ctrl dfe_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_valid_i (push_valid_i),
  .bus_err_i    (bus_err_i),
  .eu_err_i     (eu_err_i),
  .cont_i       (cont_i),
  .rst_cmd_i    (rst_cmd_i),
  .full_i       (fifo_full),
  .halted_o     (halted_o),
  .pop_valid_o  (pop_valid_o),
  .pair_ptr_o   (pair_ptr_o),
  .err_o        (err_o)
);

// File: tb/sim_desc_fetch_err_ctrl.sv
`timescale 1ns/1ps
module sim_desc_fetch_err_ctrl;
  localparam int PW = 32;
  localparam int D  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          push_valid = 0, pop_ready = 0, bus_err = 0, eu_err = 0;
  logic          clr_we = 0, cont = 0, rst_cmd = 0, adv = 0;
  logic [PW-1:0] push_ptr = '0;
  logic [4:0]    clr_mask = '0;
  logic          pop_valid, irq, halted;
  logic [PW-1:0] pop_ptr;
  logic [4:0]    err;
  logic [1:0]    pair;

  desc_fetch_err_ctrl #(.PTR_W(PW), .DEPTH(D)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .push_valid_i(push_valid), .push_ptr_i(push_ptr),
    .pop_ready_i(pop_ready), .pop_valid_o(pop_valid), .pop_ptr_o(pop_ptr),
    .bus_err_i(bus_err), .eu_err_i(eu_err), .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .cont_i(cont), .rst_cmd_i(rst_cmd), .dword_adv_i(adv), .err_o(err),
    .irq_o(irq), .halted_o(halted), .pair_ptr_o(pair)
  );

  int n_chk = 0, n_bad = 0;
  logic [PW-1:0] exp_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // driver: queue the expected pointer when the push should be kept
  task automatic push(input logic [PW-1:0] p, input bit kept);
    push_valid = 1; push_ptr = p;
    if (kept) exp_q.push_back(p);
    tick();
    push_valid = 0;
  endtask

  task automatic clear(input logic [4:0] m);
    clr_we = 1; clr_mask = m; tick(); clr_we = 0; clr_mask = '0;
  endtask

  task automatic do_cont();   cont = 1;    tick(); cont = 0;    endtask
  task automatic do_buserr(); bus_err = 1; tick(); bus_err = 0; endtask
  task automatic do_adv();    adv = 1;     tick(); adv = 0;     endtask
  task automatic do_rstcmd();
    rst_cmd = 1; exp_q.delete(); tick(); rst_cmd = 0;
  endtask

  task automatic drain(input int n);
    pop_ready = 1;
    repeat (n) tick();
    pop_ready = 0;
  endtask

  // monitor: compare every delivered pointer with the scoreboard head (R1)
  always @(negedge clk) begin
    if (rst_n && pop_valid && pop_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R1: actual extra pointer %0h expected none", pop_ptr);
      end else begin
        check("R1 order", pop_ptr, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R12 reset state
    check("R12 err", err, 0);
    check("R12 irq", irq, 0);
    check("R12 halted", halted, 0);
    check("R12 pair", pair, 0);
    check("R12 empty", pop_valid, 0);

    // R1 ordering through a full queue
    for (int i = 0; i < D; i++) push(32'hA000_0010 + i, 1);
    drain(D);
    check("R1 drained", pop_valid, 0);
    check("R1 scoreboard empty", exp_q.size(), 0);

    // R2 single overflow: pointer dropped, channel keeps running
    for (int i = 0; i < D; i++) push(32'hB000_0100 + i, 1);
    push(32'hDEAD_BEEF, 0);
    check("R2 sof", err, 5'b00010);
    check("R2 running", halted, 0);
    check("R9 irq set", irq, 1);
    drain(D + 1);
    check("R2 discarded", exp_q.size(), 0);
    check("R2 nothing left", pop_valid, 0);

    // R8 zero mask keeps bits, one clears
    clear(5'b00000);
    check("R8 zero mask", err, 5'b00010);
    clear(5'b00010);
    check("R8 cleared", err, 0);
    check("R9 irq low", irq, 0);

    // R3 double overflow halts; R4 continue keeps queue and status
    for (int i = 0; i < D; i++) push(32'hC000_1000 + i, 1);
    push(32'h1111_1111, 0);
    push(32'h2222_2222, 0);
    check("R3 dof+sof", err, 5'b00011);
    check("R3 halted", halted, 1);
    check("R10 halted code", pair, 3);
    pop_ready = 1;
    repeat (3) tick();
    check("R4 no pop", pop_valid, 0);
    check("R4 still halted", halted, 1);
    do_cont();
    check("R4 resumed", halted, 0);
    check("R4 status kept", err, 5'b00011);
    repeat (D) tick();
    pop_ready = 0;
    check("R4 queue kept", exp_q.size(), 0);
    clear(5'b00011);
    check("R8 clear two", err, 0);

    // R5 bus error halts; R11 reset command flushes
    push(32'hE000_0001, 1);
    push(32'hE000_0002, 1);
    do_buserr();
    check("R5 mdte", err, 5'b00100);
    check("R5 halted", halted, 1);
    do_adv();
    do_rstcmd();
    check("R11 err", err, 0);
    check("R11 halted", halted, 0);
    check("R11 pair", pair, 0);
    check("R11 flushed", pop_valid, 0);

    // R6 zero pointer, then R8 independent clears
    push(32'h0, 1);
    push(32'h0000_0005, 1);
    drain(2);
    check("R6 fpz", err, 5'b01000);
    do_buserr();
    check("R8 two set", err, 5'b01100);
    clear(5'b00100);
    check("R8 one cleared", err, 5'b01000);
    do_cont();
    clear(5'b01000);
    check("R8 all clear", err, 0);

    // R7 engine error held by its source
    eu_err = 1;
    tick();
    check("R7 set", err, 5'b10000);
    clear(5'b10000);
    check("R7 clear ignored", err, 5'b10000);
    eu_err = 0;
    tick();
    check("R7 sticky", err, 5'b10000);
    clear(5'b10000);
    check("R7 cleared", err, 0);

    // R10 progress counting
    do_adv(); check("R10 one", pair, 1);
    do_adv(); check("R10 two", pair, 2);
    do_adv(); check("R10 wrap", pair, 0);

    summary();
    $finish;
  end
endmodule